// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block steers a small microcontroller core between a running state, an idle state with the core clock gated, and a power-down state with the oscillator stopped. It takes the core's requests to enter idle or power-down and a hardware reset. It also takes two active-low external interrupt pins, each with an enable bit and a trigger-type bit, an oscillator-ready flag, and a strap that says whether program memory sits off chip. From these it drives the oscillator enable, the core clock gate, a one-cycle register-file reset pulse, a RAM access block, and a one-cycle resume strobe. It also drives the levels of the address-latch and program-fetch strobes, and a per-port choice of data, address or high impedance.

Power-down is left by a hardware reset, or by an enabled, level-triggered interrupt pin. The pin must stay low while the oscillator restarts, and the exit finishes when the pin goes high again. Only the interrupt exit raises the resume strobe, so the core carries on after the power-down request. A reset that ends idle lets the core run on for two machine cycles with RAM blocked before the register reset fires.

Top module: `lpm_ctrl`

## Requirements
- R1: During and after the controller reset (rst_n low), mode is RUN (code 0). osc_en and core_clk_en are 1, ale_lvl and psen_lvl are 1, and pin_force, ram_inhibit, sfr_rst and resume are 0.
- R2: In RUN, a sampled req_pd moves mode to PDWN (code 2) at the next edge, and it wins over a req_idle in the same cycle. A lone req_idle moves mode to IDLE (code 1).
- R3: In IDLE, osc_en is 1, core_clk_en is 0, ale_lvl and psen_lvl are 1, and pin_force is 1.
- R4: In PDWN and WAKE (code 3), ale_lvl and psen_lvl are 0 and core_clk_en is 0. osc_en is 0 in PDWN and 1 in WAKE.
- R5: port_sel holds two bits per port, with port p at bits [2p+1:2p], coded DATA=0, ADDR=1, FLOAT=2. With ext_pmem=0 every port is DATA in every mode.
- R6: With ext_pmem=1, port 0 is ADDR in RUN and in the reset window, and FLOAT in IDLE, PDWN and WAKE. Port 2 is ADDR in RUN, the reset window and IDLE, and DATA in PDWN and WAKE. Ports 1 and 3 are always DATA.
- R7: In IDLE, any pin that is enabled and low returns mode to RUN at the next edge, whatever its trigger-type bit.
- R8: In PDWN, a pin that is enabled, level-typed (irq_edge bit 0) and low moves mode to WAKE. A low pin that is disabled or edge-typed leaves mode in PDWN.
- R9: In WAKE, once the pin that started the wake reads high while osc_stable is 1, mode goes to RUN, and resume is 1 for exactly one cycle.
- R10: In WAKE, if the source pin goes high while osc_stable is 0, mode goes back to PDWN. If the pin stays low for OSC_MAX cycles, mode also goes back to PDWN, with no resume.
- R11: A sampled hw_rst in RUN, PDWN or WAKE gives mode RUN at the next edge, with sfr_rst 1 for that cycle.
- R12: A sampled hw_rst in IDLE enters the reset window RSTW (code 4) for 2*MC_CYC cycles. Throughout the window core_clk_en and ram_inhibit are 1. The window ends in RUN, with sfr_rst 1 for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Active-low asynchronous controller reset |
| hw_rst | input | 1 | Hardware reset request, sampled |
| req_idle | input | 1 | Core request to enter idle |
| req_pd | input | 1 | Core request to enter power-down |
| ext_irq_n | input | NIRQ | External interrupt pins, active low |
| irq_en | input | NIRQ | Per-pin interrupt enable |
| irq_edge | input | NIRQ | Per-pin trigger type, 1 edge, 0 level |
| osc_stable | input | 1 | Oscillator has settled |
| ext_pmem | input | 1 | Program memory is off chip |
| mode | output | 3 | Current mode code |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Core clock gate enable |
| sfr_rst | output | 1 | One-cycle register-file reset pulse |
| ram_inhibit | output | 1 | Blocks internal RAM access |
| resume | output | 1 | One-cycle resume strobe after interrupt wake |
| pin_force | output | 1 | Strobe levels are forced by this block |
| ale_lvl | output | 1 | Address-latch strobe level |
| psen_lvl | output | 1 | Program-fetch strobe level |
| port_sel | output | 2*NPORT | Per-port output source select |

## Verification
A wrong mode register shows up at the ports within one cycle: the oscillator enable, clock gate, strobe levels and port codes all come straight from the registered mode. Lost or extra counts in the shared counter only show after a long wait. A short reset window shows up about 24 cycles later, as an early sfr_rst. A short or missing wake timeout shows up about 64 cycles later, as a return to power-down at the wrong time. So the bench counts both windows edge by edge. It also checks that a wake completion raises resume, and that a reset exit does not.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    typedef enum logic [2:0] {
        M_RUN  = 3'd0,
        M_IDLE = 3'd1,
        M_PDWN = 3'd2,
        M_WAKE = 3'd3,
        M_RSTW = 3'd4
    } lpm_mode_e;

    typedef enum logic [1:0] {
        PS_DATA  = 2'd0,
        PS_ADDR  = 2'd1,
        PS_FLOAT = 2'd2
    } port_sel_e;
endpackage

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect #(
    parameter int NIRQ = 2,
    localparam int SW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic [NIRQ-1:0] ext_irq_n,
    input  logic [NIRQ-1:0] irq_en,
    input  logic [NIRQ-1:0] irq_edge,
    input  logic [SW-1:0]   src_idx,
    output logic            idle_wake,
    output logic            pd_trig,
    output logic [SW-1:0]   pd_src,
    output logic            src_high
);
    logic [NIRQ-1:0] active;
    logic [NIRQ-1:0] lvl_hit;

    // any enabled low pin wakes idle; only level-typed ones wake power-down
    assign active    = irq_en & ~ext_irq_n;
    assign lvl_hit   = active & ~irq_edge;
    assign idle_wake = |active;
    assign pd_trig   = |lvl_hit;
    assign src_high  = ext_irq_n[src_idx];

    // lowest-numbered qualifying pin becomes the wake source
    always_comb begin
        pd_src = '0;
        for (int i = NIRQ - 1; i >= 0; i--) begin
            if (lvl_hit[i]) pd_src = SW'(i);
        end
    end
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
#(
    parameter int NIRQ    = 2,
    parameter int MC_CYC  = 12,
    parameter int OSC_MAX = 64,
    localparam int SW   = (NIRQ > 1) ? $clog2(NIRQ) : 1,
    localparam int WIN  = 2 * MC_CYC,
    localparam int CMAX = (WIN > OSC_MAX) ? WIN : OSC_MAX,
    localparam int CW   = $clog2(CMAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hw_rst,
    input  logic          req_idle,
    input  logic          req_pd,
    input  logic          osc_stable,
    input  logic          idle_wake,
    input  logic          pd_trig,
    input  logic [SW-1:0] pd_src,
    input  logic          src_high,
    output lpm_mode_e     mode,
    output logic [SW-1:0] src_idx,
    output logic          resume,
    output logic          sfr_rst
);
    typedef struct packed {
        lpm_mode_e     mode;
        logic [CW-1:0] cnt;
        logic [SW-1:0] src;
        logic          resume;
        logic          sfr_rst;
    } fsm_st_t;

    fsm_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.resume  = 1'b0;
        st_d.sfr_rst = 1'b0;
        unique case (st_q.mode)
            M_RUN: begin
                if (hw_rst) begin
                    st_d.sfr_rst = 1'b1;
                end else if (req_pd) begin
                    st_d.mode = M_PDWN;
                end else if (req_idle) begin
                    st_d.mode = M_IDLE;
                end
            end
            M_IDLE: begin
                if (hw_rst) begin
                    st_d.mode = M_RSTW;
                    st_d.cnt  = CW'(WIN - 1);
                end else if (idle_wake) begin
                    st_d.mode = M_RUN;
                end
            end
            M_PDWN: begin
                if (hw_rst) begin
                    st_d.mode    = M_RUN;
                    st_d.sfr_rst = 1'b1;
                end else if (pd_trig) begin
                    st_d.mode = M_WAKE;
                    st_d.cnt  = '0;
                    st_d.src  = pd_src;
                end
            end
            M_WAKE: begin
                if (hw_rst) begin
                    st_d.mode    = M_RUN;
                    st_d.sfr_rst = 1'b1;
                end else if (src_high) begin
                    if (osc_stable) begin
                        st_d.mode   = M_RUN;
                        st_d.resume = 1'b1;
                    end else begin
                        st_d.mode = M_PDWN;
                    end
                end else if (st_q.cnt == CW'(OSC_MAX - 1)) begin
                    st_d.mode = M_PDWN;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            M_RSTW: begin
                if (st_q.cnt == '0) begin
                    st_d.mode    = M_RUN;
                    st_d.sfr_rst = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            default: st_d.mode = M_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: M_RUN, cnt: '0, src: '0, resume: 1'b0, sfr_rst: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode    = st_q.mode;
    assign src_idx = st_q.src;
    assign resume  = st_q.resume;
    assign sfr_rst = st_q.sfr_rst;
endmodule

// File: rtl/lpm_pin_mux.sv
module lpm_pin_mux
    import lpm_pkg::*;
#(
    parameter int NPORT     = 4,
    parameter int BUS_PORT  = 0,
    parameter int ADDR_PORT = 2
) (
    input  lpm_mode_e          mode,
    input  logic               ext_pmem,
    output logic               osc_en,
    output logic               core_clk_en,
    output logic               ram_inhibit,
    output logic               pin_force,
    output logic               ale_lvl,
    output logic               psen_lvl,
    output logic [2*NPORT-1:0] port_sel
);
    logic running;
    logic low_pwr;
    logic deep;

    assign running     = (mode == M_RUN) || (mode == M_RSTW);
    assign deep        = (mode == M_PDWN) || (mode == M_WAKE);
    assign low_pwr     = deep || (mode == M_IDLE);
    assign osc_en      = (mode != M_PDWN);
    assign core_clk_en = running;
    assign ram_inhibit = (mode == M_RSTW);
    assign pin_force   = low_pwr;
    assign ale_lvl     = !deep;
    assign psen_lvl    = !deep;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        port_sel_e sel;
        if (p == BUS_PORT) begin : g_bus
            always_comb begin
                if (!ext_pmem)    sel = PS_DATA;
                else if (running) sel = PS_ADDR;
                else              sel = PS_FLOAT;
            end
        end else if (p == ADDR_PORT) begin : g_addr
            always_comb begin
                if (ext_pmem && !deep) sel = PS_ADDR;
                else                   sel = PS_DATA;
            end
        end else begin : g_plain
            assign sel = PS_DATA;
        end
        assign port_sel[2*p +: 2] = sel;
    end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int NIRQ    = 2,
    parameter int NPORT   = 4,
    parameter int MC_CYC  = 12,
    parameter int OSC_MAX = 64,
    localparam int SW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hw_rst,
    input  logic               req_idle,
    input  logic               req_pd,
    input  logic [NIRQ-1:0]    ext_irq_n,
    input  logic [NIRQ-1:0]    irq_en,
    input  logic [NIRQ-1:0]    irq_edge,
    input  logic               osc_stable,
    input  logic               ext_pmem,
    output logic [2:0]         mode,
    output logic               osc_en,
    output logic               core_clk_en,
    output logic               sfr_rst,
    output logic               ram_inhibit,
    output logic               resume,
    output logic               pin_force,
    output logic               ale_lvl,
    output logic               psen_lvl,
    output logic [2*NPORT-1:0] port_sel
);
    lpm_mode_e     mode_e;
    logic          idle_wake;
    logic          pd_trig;
    logic          src_high;
    logic [SW-1:0] pd_src;
    logic [SW-1:0] src_idx;

    lpm_wake_detect #(.NIRQ(NIRQ)) u_wake (
        .ext_irq_n (ext_irq_n),
        .irq_en    (irq_en),
        .irq_edge  (irq_edge),
        .src_idx   (src_idx),
        .idle_wake (idle_wake),
        .pd_trig   (pd_trig),
        .pd_src    (pd_src),
        .src_high  (src_high)
    );

    lpm_fsm #(.NIRQ(NIRQ), .MC_CYC(MC_CYC), .OSC_MAX(OSC_MAX)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_rst     (hw_rst),
        .req_idle   (req_idle),
        .req_pd     (req_pd),
        .osc_stable (osc_stable),
        .idle_wake  (idle_wake),
        .pd_trig    (pd_trig),
        .pd_src     (pd_src),
        .src_high   (src_high),
        .mode       (mode_e),
        .src_idx    (src_idx),
        .resume     (resume),
        .sfr_rst    (sfr_rst)
    );

    lpm_pin_mux #(.NPORT(NPORT)) u_pins (
        .mode        (mode_e),
        .ext_pmem    (ext_pmem),
        .osc_en      (osc_en),
        .core_clk_en (core_clk_en),
        .ram_inhibit (ram_inhibit),
        .pin_force   (pin_force),
        .ale_lvl     (ale_lvl),
        .psen_lvl    (psen_lvl),
        .port_sel    (port_sel)
    );

    assign mode = mode_e;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk
    import lpm_pkg::*;
#(
    parameter int NIRQ = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hw_rst,
    input logic            req_idle,
    input logic            req_pd,
    input logic [NIRQ-1:0] ext_irq_n,
    input logic [NIRQ-1:0] irq_en,
    input logic [NIRQ-1:0] irq_edge,
    input logic [2:0]      mode,
    input logic            osc_en,
    input logic            core_clk_en,
    input logic            ale_lvl,
    input logic            psen_lvl,
    input logic            ram_inhibit,
    input logic            sfr_rst,
    input logic            resume
);
    logic lvl_any;
    assign lvl_any = |(irq_en & ~ext_irq_n & ~irq_edge);

    assert_pd_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_RUN && req_pd && !hw_rst) |=> (mode == M_PDWN));

    assert_idle_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_RUN && req_idle && !req_pd && !hw_rst) |=> (mode == M_IDLE));

    assert_idle_levels_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_IDLE) |-> (ale_lvl && psen_lvl && osc_en && !core_clk_en));

    assert_pd_levels_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_PDWN) |-> (!ale_lvl && !psen_lvl && !osc_en));

    assert_pd_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_PDWN && !hw_rst && !lvl_any) |=> (mode == M_PDWN));

    assert_resume_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> ($past(mode) == M_WAKE && mode == M_RUN));

    assert_resume_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> !resume);

    assert_hwrst_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_rst && (mode == M_PDWN || mode == M_WAKE)) |=> (sfr_rst && mode == M_RUN));

    assert_inhibit_clk_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ram_inhibit |-> core_clk_en);
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.NIRQ(NIRQ)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_rst      (hw_rst),
    .req_idle    (req_idle),
    .req_pd      (req_pd),
    .ext_irq_n   (ext_irq_n),
    .irq_en      (irq_en),
    .irq_edge    (irq_edge),
    .mode        (mode),
    .osc_en      (osc_en),
    .core_clk_en (core_clk_en),
    .ale_lvl     (ale_lvl),
    .psen_lvl    (psen_lvl),
    .ram_inhibit (ram_inhibit),
    .sfr_rst     (sfr_rst),
    .resume      (resume)
);

// File: tb/lpm_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_ctrl_tb;
    localparam int NROW = 17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_rst = 1'b0, req_idle = 1'b0, req_pd = 1'b0;
    logic [1:0] ext_irq_n = 2'b11, irq_en = 2'b11, irq_edge = 2'b00;
    logic       osc_stable = 1'b0, ext_pmem = 1'b0;
    logic [2:0] mode;
    logic       osc_en, core_clk_en, sfr_rst, ram_inhibit, resume, pin_force, ale_lvl, psen_lvl;
    logic [7:0] port_sel;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    lpm_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst), .req_idle(req_idle), .req_pd(req_pd),
        .ext_irq_n(ext_irq_n), .irq_en(irq_en), .irq_edge(irq_edge),
        .osc_stable(osc_stable), .ext_pmem(ext_pmem), .mode(mode), .osc_en(osc_en),
        .core_clk_en(core_clk_en), .sfr_rst(sfr_rst), .ram_inhibit(ram_inhibit),
        .resume(resume), .pin_force(pin_force), .ale_lvl(ale_lvl), .psen_lvl(psen_lvl),
        .port_sel(port_sel)
    );

    // inputs: ext,hw_rst,stable,req_idle,req_pd,irq_n[2],en[2],edge[2]
    localparam logic [10:0] VIN [NROW] = '{
        11'b0_0_0_0_0_11_11_00,  // run, internal
        11'b0_0_0_1_0_11_11_00,  // idle request
        11'b0_0_0_0_0_11_11_00,  // stay idle
        11'b0_0_0_0_0_10_11_00,  // pin0 low wakes idle
        11'b0_0_0_0_1_11_11_00,  // power-down request
        11'b0_0_0_0_0_10_11_01,  // edge-typed pin0 ignored
        11'b0_0_0_0_0_10_10_00,  // disabled pin0 ignored
        11'b0_0_0_0_0_01_10_00,  // pin1 low starts wake
        11'b0_0_1_0_0_01_10_00,  // stable but pin still low
        11'b0_0_1_0_0_11_10_00,  // release completes
        11'b0_0_0_0_0_11_11_00,  // resume drops
        11'b1_0_0_0_0_11_11_00,  // run, external memory
        11'b1_0_0_1_0_11_11_00,  // idle, external
        11'b1_0_0_0_0_10_11_00,  // wake idle, external
        11'b1_0_0_0_1_11_11_00,  // power-down, external
        11'b1_1_0_0_0_11_11_00,  // reset exits power-down
        11'b1_0_0_0_0_11_11_00   // pulse ends
    };
    // expected: mode3,osc,clk,ale,psen,port8,resume,sfr,ram
    localparam logic [17:0] VEX [NROW] = '{
        18'b000_1_1_1_1_00000000_0_0_0,
        18'b001_1_0_1_1_00000000_0_0_0,
        18'b001_1_0_1_1_00000000_0_0_0,
        18'b000_1_1_1_1_00000000_0_0_0,
        18'b010_0_0_0_0_00000000_0_0_0,
        18'b010_0_0_0_0_00000000_0_0_0,
        18'b010_0_0_0_0_00000000_0_0_0,
        18'b011_1_0_0_0_00000000_0_0_0,
        18'b011_1_0_0_0_00000000_0_0_0,
        18'b000_1_1_1_1_00000000_1_0_0,
        18'b000_1_1_1_1_00000000_0_0_0,
        18'b000_1_1_1_1_00010001_0_0_0,
        18'b001_1_0_1_1_00010010_0_0_0,
        18'b000_1_1_1_1_00010001_0_0_0,
        18'b010_0_0_0_0_00000010_0_0_0,
        18'b000_1_1_1_1_00010001_0_1_0,
        18'b000_1_1_1_1_00010001_0_0_0
    };
    string TAGS [NROW] = '{"R1", "R2", "R3", "R7", "R4", "R8", "R8", "R8", "R9",
                           "R9", "R9", "R6", "R6", "R7", "R6", "R11", "R11"};

    function automatic logic [17:0] observe();
        return {mode, osc_en, core_clk_en, ale_lvl, psen_lvl, port_sel, resume, sfr_rst, ram_inhibit};
    endfunction

    task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step(input logic [10:0] v);
        @(negedge clk);
        {ext_pmem, hw_rst, osc_stable, req_idle, req_pd, ext_irq_n, irq_en, irq_edge} = v;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: state while in reset and after release
        repeat (3) @(posedge clk);
        #2;
        check("R1", {observe(), pin_force}, {18'b000_1_1_1_1_00000000_0_0_0, 1'b0});
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check("R1", {observe(), pin_force}, {18'b000_1_1_1_1_00000000_0_0_0, 1'b0});

        for (int i = 0; i < NROW; i++) begin
            step(VIN[i]);
            check(TAGS[i], observe(), VEX[i]);
        end

        // R2: power-down wins over idle in the same cycle
        step(11'b0_0_0_1_1_11_11_00);
        check("R2", {15'd0, mode}, {15'd0, 3'd2});
        // R10: pin released before oscillator ready returns to power-down
        step(11'b0_0_0_0_0_10_11_00);
        check("R10", {15'd0, mode}, {15'd0, 3'd3});
        step(11'b0_0_0_0_0_11_11_00);
        check("R10", {16'd0, mode, resume}, {16'd0, 3'd2, 1'b0});
        // R10: wake timeout after 64 cycles with pin held low
        step(11'b0_0_0_0_0_10_11_00);
        for (int k = 0; k < 63; k++) begin
            step(11'b0_0_0_0_0_10_11_00);
            if (mode !== 3'd3) check("R10", {15'd0, mode}, {15'd0, 3'd3});
        end
        step(11'b0_0_0_0_0_10_11_00);
        check("R10", {16'd0, mode, resume}, {16'd0, 3'd2, 1'b0});
        // R11: reset during wake
        step(11'b0_0_0_0_0_11_11_00);
        step(11'b0_0_0_0_0_10_11_00);
        check("R11", {15'd0, mode}, {15'd0, 3'd3});
        step(11'b0_1_0_0_0_10_11_00);
        check("R11", {13'd0, mode, sfr_rst, resume}, {13'd0, 3'd0, 1'b1, 1'b0});
        // R12: reset ends idle through a 24-cycle window
        step(11'b1_0_0_1_0_11_11_00);
        check("R3", {17'd0, pin_force}, 18'd1);
        step(11'b1_1_0_0_0_11_11_00);
        check("R12", observe(), 18'b100_1_1_1_1_00010001_0_0_1);
        for (int k = 0; k < 23; k++) begin
            step(11'b1_0_0_0_0_11_11_00);
            if (mode !== 3'd4 || ram_inhibit !== 1'b1 || sfr_rst !== 1'b0)
                check("R12", observe(), 18'b100_1_1_1_1_00010001_0_0_1);
        end
        step(11'b1_0_0_0_0_11_11_00);
        check("R12", observe(), 18'b000_1_1_1_1_00010001_0_1_0);
        // R5: internal memory keeps all ports on data in idle
        step(11'b0_0_0_1_0_11_11_00);
        check("R5", {7'd0, mode, port_sel}, {7'd0, 3'd1, 8'h00});
        // R7: edge-typed enabled pin still wakes idle
        step(11'b0_0_0_0_0_01_11_10);
        check("R7", {15'd0, mode}, {15'd0, 3'd0});

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule